// File: doc/BRIEF.md
# Page-Mode DRAM Controller with Built-In Refresh

This block sits between a processor-style request channel and one bank of fast-page or extended-data-out DRAM whose address pins carry the row and the column one after the other. Each accepted request opens a row by lowering the row strobe with the row half of the address on the pins, then lowers the column strobes of the selected byte lanes with the column half, holds them for a programmed number of clocks and returns one response beat. The row strobe is then raised and kept high for a programmed precharge time before the next cycle may start. Every timing phase is given in clock counts.

Refresh is done by the same sequencer in column-before-row order: all column strobes fall while the row strobe is high, and then the row strobe falls. No address is needed. An interval counter makes a refresh due at a fixed period, and a due refresh wins over a waiting request. After reset the controller runs a burst of eight back-to-back refreshes before it accepts any access. The power-on settling delay is assumed to be covered by the external reset.

A small geometry register, reached through the same request channel, sets how many word-address bits go to the column and how many go to the row. Modules of equal capacity but different row/column splits therefore appear as one contiguous block of words. Requests use valid/ready: the request is taken on the clock where both are high. Only one request is in flight at a time, and `req_ready` stays low until the response has been given and precharge is over. The response is a one-cycle `resp_valid` pulse that cannot be stalled, so the requester must be able to take it at any time.

Top module: `dram_ctrl`

## Requirements
- R1: After reset, `req_ready` stays low until eight column-before-row refreshes have been issued.
- R2: An access holds `mem_ras_n` low with the row on `mem_addr` for T_RCD clocks, then lowers the column strobes with the column on `mem_addr` for T_CAS clocks. `resp_valid` is a single-cycle pulse that appears T_RCD+T_CAS+1 falling edges after the accepting edge. For a read it carries `mem_dq_in` as sampled at the last column clock.
- R3: `mem_ras_n` stays high for at least T_RP clocks before it falls again.
- R4: A refresh lowers all column strobes while `mem_ras_n` is high and lowers `mem_ras_n` afterwards. Column strobes are never partly low while `mem_ras_n` is high.
- R5: A refresh becomes due once every REF_INTERVAL clocks, including during steady traffic. While one is due, `req_ready` is low.
- R6: Bit i of `req_be` drives `mem_cas_n[i]`, which serves data bits 8i+7:8i. A write leaves the bytes of disabled lanes unchanged.
- R7: `mem_we_n` is low and `mem_dq_oe` is high only during write accesses, and only while `mem_ras_n` is low.
- R8: With column width C = 8 + column code and row width R = 8 + row code, the column is word-address bits C-1:0 and the row is bits C+R-1:C. Unused upper bits of `mem_addr` are zero.
- R9: Geometry register: an access with `req_cfg` = 1 and `req_write` = 1 loads the column code from `req_wdata[3:0]` and the row code from `req_wdata[7:4]`. A code above 4 is stored as 4. The response data is `{24'b0, row_code, col_code}`, and the reset value is 0x44.
- R10: A geometry access returns `resp_valid` at the second falling edge after the accepting edge, leaves all DRAM strobes high, and is followed by `req_ready` again.
- R11: A request is taken only on a clock where `req_valid` and `req_ready` are both high. Its address, lanes and data are captured at that edge.
- R12: `mem_addr` stays stable while any column strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this clock |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cfg | input | 1 | 1 = geometry register, 0 = DRAM |
| req_addr | input | 24 | Word address |
| req_be | input | 4 | Byte-lane enables |
| req_wdata | input | 32 | Write data |
| resp_valid | output | 1 | Response pulse |
| resp_rdata | output | 32 | Response data |
| mem_addr | output | 12 | Multiplexed row/column address |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 4 | Per-lane column strobes, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_out | output | 32 | Data toward DRAM |
| mem_dq_oe | output | 1 | Data output enable |
| mem_dq_in | input | 32 | Data from DRAM |

## Verification
The assertions check on every cycle the pin rules that hold regardless of traffic: precharge length, column-before-row order with all-or-nothing strobes while the row strobe is high, write enable only under an open row, a stable address while column strobes are low, ready withheld while a refresh is due or during the startup burst, and single-cycle responses. Only the bench scenarios can show the values. They cover data round trips through a DRAM model, partial-lane merges, the exact row/column split for several geometries, clamping of out-of-range codes, response latency, and the refresh count over idle and busy windows.

// File: rtl/dram_pkg.sv
package dram_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ROW, ST_COL, ST_PRE, ST_RCAS, ST_RRAS, ST_CFG
  } seq_state_t;

  typedef struct packed {
    logic [3:0] row_code;
    logic [3:0] col_code;
  } geom_t;

  localparam logic [3:0] CODE_MAX = 4'd4;

  function automatic logic [3:0] clamp_code(input logic [3:0] c);
    return (c > CODE_MAX) ? CODE_MAX : c;
  endfunction
endpackage

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int REF_INTERVAL = 780,
  parameter int INIT_REFS    = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic grant,
  output logic ref_req
);
  localparam int CNT_W  = $clog2(REF_INTERVAL + 1);
  localparam int INIT_W = $clog2(INIT_REFS + 1);

  logic [CNT_W-1:0]  ivl_q;
  logic [INIT_W-1:0] init_left_q;
  logic              pend_q;
  logic              tick;

  assign tick    = (ivl_q == '0);
  assign ref_req = pend_q || (init_left_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ivl_q       <= CNT_W'(REF_INTERVAL - 1);
      init_left_q <= INIT_W'(INIT_REFS);
      pend_q      <= 1'b0;
    end else begin
      ivl_q <= tick ? CNT_W'(REF_INTERVAL - 1) : ivl_q - 1'b1;
      if (grant && init_left_q != '0)
        init_left_q <= init_left_q - 1'b1;
      pend_q <= (pend_q && !(grant && init_left_q == '0)) || tick;
    end
  end

  // R5
  grant_when_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> ref_req);

  // R5
  refresh_not_lost_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && pend_q) |-> grant);
endmodule

// File: rtl/dram_addr_split.sv
module dram_addr_split #(
  parameter int ADDR_W = 24,
  parameter int MA_W   = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  dram_pkg::geom_t   geom,
  output logic [MA_W-1:0]   row,
  output logic [MA_W-1:0]   col
);
  localparam int MIN_BITS = MA_W - 4;
  localparam int SH_W     = $clog2(MA_W + 1);

  logic [SH_W-1:0]   col_bits, row_bits;
  logic [ADDR_W-1:0] upper;

  always_comb begin
    col_bits = SH_W'(MIN_BITS) + SH_W'(geom.col_code);
    row_bits = SH_W'(MIN_BITS) + SH_W'(geom.row_code);
    upper    = addr >> col_bits;
    for (int i = 0; i < MA_W; i++) begin
      col[i] = (SH_W'(i) < col_bits) ? addr[i]  : 1'b0;
      row[i] = (SH_W'(i) < row_bits) ? upper[i] : 1'b0;
    end
  end
endmodule

// File: rtl/dram_seq.sv
module dram_seq #(
  parameter int MA_W   = 12,
  parameter int DQ_W   = 32,
  parameter int LANES  = 4,
  parameter int T_RCD  = 2,
  parameter int T_CAS  = 2,
  parameter int T_RP   = 2,
  parameter int T_RAS  = 3,
  parameter int T_CBR  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_req,
  output logic             ref_grant,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic             req_cfg,
  input  logic [LANES-1:0] req_be,
  input  logic [DQ_W-1:0]  req_wdata,
  input  logic [MA_W-1:0]  row,
  input  logic [MA_W-1:0]  col,
  output logic             cfg_we,
  input  logic [DQ_W-1:0]  cfg_rdata,
  output logic             resp_valid,
  output logic [DQ_W-1:0]  resp_rdata,
  output logic [MA_W-1:0]  mem_addr,
  output logic             mem_ras_n,
  output logic [LANES-1:0] mem_cas_n,
  output logic             mem_we_n,
  output logic [DQ_W-1:0]  mem_dq_out,
  output logic             mem_dq_oe,
  input  logic [DQ_W-1:0]  mem_dq_in
);
  import dram_pkg::*;

  localparam int M1    = (T_RCD > T_CAS) ? T_RCD : T_CAS;
  localparam int M2    = (T_RP > T_RAS) ? T_RP : T_RAS;
  localparam int M3    = (M1 > M2) ? M1 : M2;
  localparam int TMAX  = (M3 > T_CBR) ? M3 : T_CBR;
  localparam int TMR_W = $clog2(TMAX + 1);
  localparam int HI_W  = $clog2(T_RP + 2);

  seq_state_t       state_q;
  logic [TMR_W-1:0] tmr_q;
  logic [MA_W-1:0]  col_q;
  logic [LANES-1:0] be_q;
  logic             accept, tmr_done;

  assign req_ready = (state_q == ST_IDLE) && !ref_req;
  assign ref_grant = (state_q == ST_IDLE) && ref_req;
  assign accept    = req_ready && req_valid;
  assign cfg_we    = accept && req_cfg && req_write;
  assign tmr_done  = (tmr_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      tmr_q      <= '0;
      col_q      <= '0;
      be_q       <= '0;
      resp_valid <= 1'b0;
      resp_rdata <= '0;
      mem_addr   <= '0;
      mem_ras_n  <= 1'b1;
      mem_cas_n  <= '1;
      mem_we_n   <= 1'b1;
      mem_dq_out <= '0;
      mem_dq_oe  <= 1'b0;
    end else begin
      resp_valid <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (ref_grant) begin
            state_q   <= ST_RCAS;
            mem_cas_n <= '0;
            tmr_q     <= TMR_W'(T_CBR - 1);
          end else if (accept) begin
            if (req_cfg) begin
              state_q <= ST_CFG;
            end else begin
              state_q    <= ST_ROW;
              mem_ras_n  <= 1'b0;
              mem_addr   <= row;
              col_q      <= col;
              be_q       <= req_be;
              mem_we_n   <= !req_write;
              mem_dq_oe  <= req_write;
              mem_dq_out <= req_wdata;
              tmr_q      <= TMR_W'(T_RCD - 1);
            end
          end
        end
        ST_ROW: begin
          if (tmr_done) begin
            state_q   <= ST_COL;
            mem_addr  <= col_q;
            mem_cas_n <= ~be_q;
            tmr_q     <= TMR_W'(T_CAS - 1);
          end else begin
            tmr_q <= tmr_q - 1'b1;
          end
        end
        ST_COL: begin
          if (tmr_done) begin
            state_q    <= ST_PRE;
            resp_valid <= 1'b1;
            resp_rdata <= mem_dq_in;
            mem_ras_n  <= 1'b1;
            mem_cas_n  <= '1;
            mem_we_n   <= 1'b1;
            mem_dq_oe  <= 1'b0;
            tmr_q      <= TMR_W'(T_RP - 1);
          end else begin
            tmr_q <= tmr_q - 1'b1;
          end
        end
        ST_RCAS: begin
          if (tmr_done) begin
            state_q   <= ST_RRAS;
            mem_ras_n <= 1'b0;
            tmr_q     <= TMR_W'(T_RAS - 1);
          end else begin
            tmr_q <= tmr_q - 1'b1;
          end
        end
        ST_RRAS: begin
          if (tmr_done) begin
            state_q   <= ST_PRE;
            mem_ras_n <= 1'b1;
            mem_cas_n <= '1;
            tmr_q     <= TMR_W'(T_RP - 1);
          end else begin
            tmr_q <= tmr_q - 1'b1;
          end
        end
        ST_PRE: begin
          if (tmr_done) state_q <= ST_IDLE;
          else          tmr_q   <= tmr_q - 1'b1;
        end
        ST_CFG: begin
          resp_valid <= 1'b1;
          resp_rdata <= cfg_rdata;
          state_q    <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // Cycles the row strobe has been high; starts saturated because the
  // power-on wait is covered outside the block.
  logic [HI_W-1:0] hi_cnt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          hi_cnt_q <= HI_W'(T_RP);
    else if (!mem_ras_n) hi_cnt_q <= '0;
    else if (hi_cnt_q < HI_W'(T_RP)) hi_cnt_q <= hi_cnt_q + 1'b1;
  end

  // R3
  precharge_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ras_n) |-> (hi_cnt_q >= HI_W'(T_RP)));

  // R4
  cbr_all_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_ras_n && mem_cas_n != '1) |-> (mem_cas_n == '0));

  // R7
  we_under_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n || mem_dq_oe) |-> (!mem_ras_n && !mem_we_n));

  // R2
  resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);

  // R12
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cas_n != '1 && $past(mem_cas_n != '1)) |-> $stable(mem_addr));

  // R10
  cfg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CFG) |-> (mem_ras_n && mem_cas_n == '1));
endmodule

// File: rtl/dram_ctrl.sv
module dram_ctrl #(
  parameter int ADDR_W       = 24,
  parameter int MA_W         = 12,
  parameter int DQ_W         = 32,
  parameter int T_RCD        = 2,
  parameter int T_CAS        = 2,
  parameter int T_RP         = 2,
  parameter int T_RAS        = 3,
  parameter int T_CBR        = 1,
  parameter int REF_INTERVAL = 780,
  parameter int INIT_REFS    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic                req_cfg,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DQ_W/8-1:0]   req_be,
  input  logic [DQ_W-1:0]     req_wdata,
  output logic                resp_valid,
  output logic [DQ_W-1:0]     resp_rdata,
  output logic [MA_W-1:0]     mem_addr,
  output logic                mem_ras_n,
  output logic [DQ_W/8-1:0]   mem_cas_n,
  output logic                mem_we_n,
  output logic [DQ_W-1:0]     mem_dq_out,
  output logic                mem_dq_oe,
  input  logic [DQ_W-1:0]     mem_dq_in
);
  import dram_pkg::*;

  localparam int LANES  = DQ_W / 8;
  localparam int INIT_W = $clog2(INIT_REFS + 1);

  geom_t           geom_q;
  logic            ref_req, ref_grant, cfg_we;
  logic [MA_W-1:0] row, col;
  logic [DQ_W-1:0] cfg_rdata;

  assign cfg_rdata = {{(DQ_W-8){1'b0}}, geom_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      geom_q <= '{row_code: CODE_MAX, col_code: CODE_MAX};
    end else if (cfg_we) begin
      geom_q.row_code <= clamp_code(req_wdata[7:4]);
      geom_q.col_code <= clamp_code(req_wdata[3:0]);
    end
  end

  dram_refresh_sched #(
    .REF_INTERVAL(REF_INTERVAL), .INIT_REFS(INIT_REFS)
  ) i_refresh (
    .clk(clk), .rst_n(rst_n), .grant(ref_grant), .ref_req(ref_req)
  );

  dram_addr_split #(.ADDR_W(ADDR_W), .MA_W(MA_W)) i_split (
    .addr(req_addr), .geom(geom_q), .row(row), .col(col)
  );

  dram_seq #(
    .MA_W(MA_W), .DQ_W(DQ_W), .LANES(LANES), .T_RCD(T_RCD), .T_CAS(T_CAS),
    .T_RP(T_RP), .T_RAS(T_RAS), .T_CBR(T_CBR)
  ) i_seq (
    .clk(clk), .rst_n(rst_n), .ref_req(ref_req), .ref_grant(ref_grant),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_cfg(req_cfg), .req_be(req_be), .req_wdata(req_wdata),
    .row(row), .col(col), .cfg_we(cfg_we), .cfg_rdata(cfg_rdata),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata),
    .mem_addr(mem_addr), .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n),
    .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  // Refreshes granted since reset, saturating at the burst length.
  logic [INIT_W-1:0] burst_seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) burst_seen_q <= '0;
    else if (ref_grant && burst_seen_q < INIT_W'(INIT_REFS))
      burst_seen_q <= burst_seen_q + 1'b1;
  end

  // R1
  init_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (burst_seen_q == INIT_W'(INIT_REFS)));

  // R5
  ready_yields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !ref_req);

  // R9
  geom_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (geom_q.row_code <= CODE_MAX) && (geom_q.col_code <= CODE_MAX));
endmodule

// File: tb/test_dram_ctrl.sv
`timescale 1ns/1ps
module test_dram_ctrl;
  localparam int T_RCD = 2, T_CAS = 2, T_RP = 2, T_RAS = 3, REF_IVL = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_cfg = 1'b0;
  logic [23:0] req_addr = '0;
  logic [3:0]  req_be = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, resp_valid, mem_ras_n, mem_we_n, mem_dq_oe;
  logic [31:0] resp_rdata, mem_dq_out;
  logic [31:0] mem_dq_in = '0;
  logic [11:0] mem_addr;
  logic [3:0]  mem_cas_n;

  int n_tests = 0, n_fail = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  dram_ctrl #(.T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP), .T_RAS(T_RAS),
              .REF_INTERVAL(REF_IVL)) i_dram_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_cfg(req_cfg), .req_addr(req_addr),
    .req_be(req_be), .req_wdata(req_wdata), .resp_valid(resp_valid),
    .resp_rdata(resp_rdata), .mem_addr(mem_addr), .mem_ras_n(mem_ras_n),
    .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  // ---------------- DRAM model ----------------
  logic [31:0] dmem [int];
  logic        p_ras = 1'b1;
  logic [3:0]  p_cas = 4'hF;
  logic [11:0] p_addr = '0;
  logic [11:0] cur_row = '0, last_row = '0, last_col = '0;
  int cbr_cnt = 0, acc_cnt = 0, hi_len = 1000, min_hi = 1000;
  int bad_cbr = 0, bad_addr = 0, bad_we = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n) begin
      if (p_ras && !mem_ras_n) begin
        if (hi_len < min_hi) min_hi = hi_len;
        if (mem_cas_n == 4'h0 && p_cas == 4'h0) cbr_cnt++;
        else begin cur_row = mem_addr; acc_cnt++; end
      end
      if (mem_ras_n && mem_cas_n != 4'hF && mem_cas_n != 4'h0) bad_cbr++;
      if (p_cas != 4'hF && mem_cas_n != 4'hF && mem_addr != p_addr) bad_addr++;
      if ((!mem_we_n && mem_ras_n) || (mem_dq_oe && mem_we_n)) bad_we++;
      if (!mem_ras_n && ((p_cas & ~mem_cas_n) != 4'h0)) begin
        int key;
        logic [31:0] w;
        key = int'({cur_row, mem_addr});
        last_row = cur_row;
        last_col = mem_addr;
        w = dmem.exists(key) ? dmem[key] : 32'h0;
        if (!mem_we_n) begin
          for (int i = 0; i < 4; i++)
            if (p_cas[i] && !mem_cas_n[i]) w[8*i +: 8] = mem_dq_out[8*i +: 8];
          dmem[key] = w;
        end else begin
          mem_dq_in <= w;
        end
      end
      hi_len = mem_ras_n ? hi_len + 1 : 0;
    end
    p_ras  = mem_ras_n;
    p_cas  = mem_cas_n;
    p_addr = mem_addr;
  end

  // ---------------- helpers ----------------
  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_req(input logic wr, input logic cf, input logic [23:0] a,
                        input logic [3:0] be, input logic [31:0] wd,
                        output logic [31:0] rd, output int lat);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_cfg = cf;
    req_addr = a; req_be = be; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    req_addr = $urandom; req_wdata = $urandom; req_be = $urandom;
    lat = 1;
    while (!resp_valid) begin @(negedge clk); lat++; end
    rd = resp_rdata;
  endtask

  function automatic logic [11:0] exp_col(input logic [23:0] a, input int cb);
    return 12'(a & ((24'd1 << cb) - 1));
  endfunction
  function automatic logic [11:0] exp_row(input logic [23:0] a, input int cb, input int rb);
    return 12'((a >> cb) & ((24'd1 << rb) - 1));
  endfunction
  function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n,
                                        input logic [3:0] be);
    logic [31:0] r = o;
    for (int i = 0; i < 4; i++) if (be[i]) r[8*i +: 8] = n[8*i +: 8];
    return r;
  endfunction

  // ---------------- watchdog ----------------
  initial begin
    wait (cyc > 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual cycles %0d expected < 150000", cyc);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  // ---------------- scenarios ----------------
  initial begin
    logic [31:0] rd;
    int lat, c0, cb0, acc0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 reset ready low", {31'b0, req_ready}, 32'd0);
    check("R2 reset resp low", {31'b0, resp_valid}, 32'd0);
    rst_n = 1'b1;
    while (!req_ready) @(negedge clk);
    check("R1 eight refreshes before first ready", cbr_cnt, 8);

    // R9 reset value and clamp
    do_req(1'b0, 1'b1, '0, 4'hF, '0, rd, lat);
    check("R9 reset geometry", rd, 32'h44);
    check("R10 cfg latency", lat, 2);
    acc0 = acc_cnt;
    do_req(1'b1, 1'b1, '0, 4'hF, 32'hFFFF_FF97, rd, lat);
    check("R9 clamp codes", rd, 32'h44);
    do_req(1'b1, 1'b1, '0, 4'hF, 32'h0000_0012, rd, lat);
    check("R9 write codes", rd, 32'h12);
    check("R10 cfg no DRAM cycle", acc_cnt, acc0);
    check("R10 ready after cfg", 32'(req_ready || cbr_cnt > 0), 32'd1);

    // Three geometries: {row_code,col_code}
    for (int g = 0; g < 3; g++) begin
      logic [7:0] code;
      int cb, rb;
      code = (g == 0) ? 8'h44 : (g == 1) ? 8'h12 : 8'h21;
      cb = 8 + int'(code[3:0]);
      rb = 8 + int'(code[7:4]);
      do_req(1'b1, 1'b1, '0, 4'hF, {24'b0, code}, rd, lat);
      check("R9 geometry set", rd, {24'b0, code});
      for (int k = 0; k < 10; k++) begin
        logic [23:0] a;
        logic [31:0] d0, d1;
        logic [3:0]  be;
        a  = 24'($urandom) & ((24'd1 << (cb + rb)) - 1);
        if (k == 0) a = (24'd1 << (cb + rb)) - 1;
        if (k == 1) a = 24'd1 << cb;
        d0 = $urandom; d1 = $urandom; be = 4'($urandom);
        if (k == 2) be = 4'b0101;
        if (k == 3) be = 4'b0000;
        do_req(1'b1, 1'b0, a, 4'hF, d0, rd, lat);
        check("R2 write latency", lat, T_RCD + T_CAS + 1);
        check("R8 row split", {20'b0, last_row}, {20'b0, exp_row(a, cb, rb)});
        check("R8 column split", {20'b0, last_col}, {20'b0, exp_col(a, cb)});
        do_req(1'b1, 1'b0, a, be, d1, rd, lat);
        do_req(1'b0, 1'b0, a, 4'hF, '0, rd, lat);
        check("R6 lane merge readback", rd, merge(d0, d1, be));
        check("R2 read latency", lat, T_RCD + T_CAS + 1);
      end
    end

    // R11: inputs changed after acceptance must not matter (do_req scrambles them)
    do_req(1'b1, 1'b0, 24'h000321, 4'hF, 32'hCAFE_0123, rd, lat);
    do_req(1'b0, 1'b0, 24'h000321, 4'hF, '0, rd, lat);
    check("R11 captured at accept", rd, 32'hCAFE_0123);

    // R5 idle refresh rate
    @(negedge clk);
    c0 = cbr_cnt;
    repeat (640) @(negedge clk);
    n_tests++;
    if (cbr_cnt - c0 < 9 || cbr_cnt - c0 > 11) begin
      n_fail++;
      $display("FAIL R5 idle refresh count: actual %0d expected 10", cbr_cnt - c0);
    end

    // R5 refresh under busy traffic
    c0 = cyc; cb0 = cbr_cnt;
    for (int k = 0; k < 60; k++)
      do_req(1'b0, 1'b0, 24'($urandom) & 24'hFFFF, 4'hF, '0, rd, lat);
    n_tests++;
    if (cbr_cnt - cb0 < (cyc - c0) / REF_IVL - 1 || cbr_cnt - cb0 > (cyc - c0) / REF_IVL + 1) begin
      n_fail++;
      $display("FAIL R5 busy refresh count: actual %0d expected %0d", cbr_cnt - cb0,
               (cyc - c0) / REF_IVL);
    end

    check("R3 min precharge ok", 32'(min_hi >= T_RP), 32'd1);
    check("R4 partial CAS under high RAS", bad_cbr, 0);
    check("R7 write strobes outside row", bad_we, 0);
    check("R12 address moved under CAS", bad_addr, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule